// File: doc/BRIEF.md
# Watchdog Timer with Shared Assignable Scaler

This block is a watchdog timer that counts a free-running watchdog tick up to a programmable base period. An 8-bit ripple scaler is shared between the watchdog and a general-purpose timer, and one bit of an 8-bit option register decides which of the two owns it. When the watchdog owns the scaler, the scaler acts as a postscaler and stretches the time-out period. When the timer owns it, the scaler acts as a prescaler on the timer's source tick, and the watchdog expires at its bare base period.

Software keeps the watchdog from expiring with a clear strobe. The sleep-entry strobe restarts the count in the same way, so a sleeping system gets the full period before the watchdog wakes it. A configuration-level enable turns the watchdog on or off as a whole. Both results are registered, single-cycle pulses: a time-out pulse and a scaled tick for the timer. The option register contents are brought out for the timer logic and for readback.

Top module: `wdt_shared_scaler`

## Requirements
- R1: After reset the option register reads 8'hFF. A write with `optWrEn` high loads `optWrData`, and the new value is visible on `optValue` one cycle later. Bit 3 is the scaler-assignment bit (1 gives the scaler to the watchdog). Bits 2:0 are the rate code n. Bits 7:4 are stored for the timer logic only.
- R2: With bit 3 clear and the watchdog enabled, `wdtTimeout` pulses in the cycle after the clock edge that samples the BASE_TICKS-th `wdtTick` counted since the last restart.
- R3: With bit 3 set, each base-period expiry advances the scaler, and `wdtTimeout` pulses after BASE_TICKS·2^n watchdog ticks.
- R4: With bit 3 clear, `timerTick` pulses on every 2^(n+1)-th `timerSrcTick`, so codes 0 to 7 give division by 2 to 256. The pulse appears one cycle after the edge that samples the source tick.
- R5: With bit 3 set, `timerTick` repeats each `timerSrcTick` one cycle later, without division.
- R6: `clearWdt` restarts the base count and, when bit 3 is set, also clears the scaler. A full period must then elapse before a time-out.
- R7: `sleepEntry` has the same restart effect as `clearWdt`.
- R8: A clear or sleep strobe in the same cycle as the final expiring tick wins. No time-out is issued, and the full period starts again.
- R9: While `wdtEnable` is low, no time-out is produced and the watchdog counts are held at zero. After re-enabling, a full period runs from zero.
- R10: A write that changes bit 3 clears the scaler in that cycle, so the new owner starts from a zero count.
- R11: Each time-out is a single-cycle pulse. After it, the base count and the watchdog-owned scaler restart from zero, so the next time-out needs another full period.
- R12: While bit 3 is clear, `clearWdt` leaves the timer prescaler count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wdtEnable | input | 1 | Configuration-level watchdog enable |
| wdtTick | input | 1 | Free-running watchdog base tick |
| timerSrcTick | input | 1 | Timer clock-source tick |
| clearWdt | input | 1 | Clear-watchdog strobe |
| sleepEntry | input | 1 | Sleep-entry strobe |
| optWrEn | input | 1 | Option register write enable |
| optWrData | input | 8 | Option register write data |
| optValue | output | 8 | Option register contents |
| wdtTimeout | output | 1 | Watchdog time-out pulse |
| timerTick | output | 1 | Scaled (or passed-through) timer tick |

## Verification
Both `wdtTimeout` and `timerTick` are registered. Each one is due exactly one cycle after the clock edge that samples the tick completing its count, and an option write shows on `optValue` one cycle after it is sampled. The driver pushes the cycle number of every expected pulse into a queue when it drives the tick that should cause the pulse, using the current cycle plus one. On each falling edge the monitor compares both outputs against the queue heads. A missing pulse, an early pulse and a pulse that lasts two cycles are all reported against the requirement under test. Stretches in which clears, sleep, disabling or reassignment must delay a time-out expect no pulse at all, so any time-out that comes early is flagged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OPT_W          = 8;
  localparam int RATE_W         = 3;
  localparam int OPT_ASSIGN_BIT = 3;
  localparam int SCALE_W        = 1 << RATE_W;
  localparam int STAGE_W        = $clog2(SCALE_W + 1);

  typedef struct packed {
    logic baseStep;
    logic baseClear;
    logic scalerStep;
    logic scalerClear;
    logic wdtFire;
    logic timerFire;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wdtEnable,
  input  logic                wdtTick,
  input  logic                timerSrcTick,
  input  logic                clearWdt,
  input  logic                sleepEntry,
  input  logic                optWrEn,
  input  logic [OPT_W-1:0]    optWrData,
  input  logic                baseAtMax,
  input  logic                scaleHit,
  output logic [OPT_W-1:0]    optValue,
  output logic [STAGE_W-1:0]  stageSel,
  output wdtStrobes_t         strobes
);
  logic [OPT_W-1:0]  optQ;
  logic [RATE_W-1:0] rateCode;
  logic              assignWdt;
  logic              clrAny;
  logic              assignFlip;
  logic              baseExpire;
  logic              scaleEvent;
  logic              scaledOut;

  // option register: all ones on every reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        optQ <= '1;
    else if (optWrEn) optQ <= optWrData;
  end

  assign optValue = optQ;

  always_comb begin
    assignWdt  = optQ[OPT_ASSIGN_BIT];
    rateCode   = optQ[RATE_W-1:0];
    // watchdog owner divides by 2^n, timer owner by 2^(n+1)
    stageSel   = assignWdt ? STAGE_W'(rateCode) : STAGE_W'(rateCode) + STAGE_W'(1);
    clrAny     = clearWdt | sleepEntry;
    assignFlip = optWrEn && (optWrData[OPT_ASSIGN_BIT] != assignWdt);

    strobes.baseStep  = wdtEnable && wdtTick && !clrAny;
    baseExpire        = strobes.baseStep && baseAtMax;
    scaleEvent        = assignWdt ? baseExpire : timerSrcTick;
    scaledOut         = scaleEvent && scaleHit && !assignFlip;

    strobes.wdtFire   = assignWdt ? scaledOut : baseExpire;
    strobes.timerFire = assignWdt ? timerSrcTick : scaledOut;
    strobes.baseClear = clrAny || !wdtEnable || baseExpire;
    strobes.scalerClear = assignFlip ||
                          (assignWdt && (clrAny || !wdtEnable || strobes.wdtFire));
    strobes.scalerStep  = scaleEvent && !strobes.scalerClear;
  end

  AST_OPT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    optWrEn |=> (optValue == $past(optWrData)));  // R1
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 18
) (
  input  logic               clk,
  input  logic               rstN,
  input  wdtStrobes_t        strobes,
  input  logic [STAGE_W-1:0] stageSel,
  output logic               baseAtMax,
  output logic               scaleHit,
  output logic               wdtTimeout,
  output logic               timerTick
);
  localparam int BASE_W = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;

  logic [BASE_W-1:0]  baseCnt;
  logic [SCALE_W-1:0] scaleCnt;
  logic [SCALE_W:0]   lowOnes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 baseCnt <= '0;
    else if (strobes.baseClear) baseCnt <= '0;
    else if (strobes.baseStep)  baseCnt <= baseCnt + BASE_W'(1);
  end

  assign baseAtMax = (baseCnt == BASE_W'(BASE_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    scaleCnt <= '0;
    else if (strobes.scalerClear) scaleCnt <= '0;
    else if (strobes.scalerStep)  scaleCnt <= scaleCnt + SCALE_W'(1);
  end

  // lowOnes[k] is high when the low k scaler stages are all ones
  assign lowOnes[0] = 1'b1;
  for (genvar g = 0; g < SCALE_W; g++) begin : g_stage
    assign lowOnes[g+1] = lowOnes[g] & scaleCnt[g];
  end

  assign scaleHit = lowOnes[stageSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtTimeout <= 1'b0;
      timerTick  <= 1'b0;
    end else begin
      wdtTimeout <= strobes.wdtFire;
      timerTick  <= strobes.timerFire;
    end
  end

  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    baseCnt < BASE_W'(BASE_TICKS));  // R2
  AST_SCALER_ZEROED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.scalerClear |=> (scaleCnt == '0));  // R10
endmodule

// File: rtl/wdt_shared_scaler.sv
module wdt_shared_scaler
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdtEnable,
  input  logic             wdtTick,
  input  logic             timerSrcTick,
  input  logic             clearWdt,
  input  logic             sleepEntry,
  input  logic             optWrEn,
  input  logic [OPT_W-1:0] optWrData,
  output logic [OPT_W-1:0] optValue,
  output logic             wdtTimeout,
  output logic             timerTick
);
  wdtStrobes_t        strobes;
  logic [STAGE_W-1:0] stageSel;
  logic               baseAtMax;
  logic               scaleHit;

  wdt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wdtEnable    (wdtEnable),
    .wdtTick      (wdtTick),
    .timerSrcTick (timerSrcTick),
    .clearWdt     (clearWdt),
    .sleepEntry   (sleepEntry),
    .optWrEn      (optWrEn),
    .optWrData    (optWrData),
    .baseAtMax    (baseAtMax),
    .scaleHit     (scaleHit),
    .optValue     (optValue),
    .stageSel     (stageSel),
    .strobes      (strobes)
  );

  wdt_datapath #(.BASE_TICKS(BASE_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .stageSel   (stageSel),
    .baseAtMax  (baseAtMax),
    .scaleHit   (scaleHit),
    .wdtTimeout (wdtTimeout),
    .timerTick  (timerTick)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clearWdt || sleepEntry) |=> !wdtTimeout);  // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEnable |=> !wdtTimeout);  // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout);  // R11
endmodule

// File: tb/wdt_shared_scaler_tb.sv
module wdt_shared_scaler_tb;
  localparam int BASE = 6;

  typedef struct {
    int    cyc;
    string req;
  } expect_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdtEnable = 1'b1;
  logic       wdtTick = 1'b0;
  logic       timerSrcTick = 1'b0;
  logic       clearWdt = 1'b0;
  logic       sleepEntry = 1'b0;
  logic       optWrEn = 1'b0;
  logic [7:0] optWrData = '0;
  logic [7:0] optValue;
  logic       wdtTimeout;
  logic       timerTick;

  int      cyc = 0;
  int      checks = 0;
  int      fails = 0;
  bit      done = 1'b0;
  expect_t qWdt[$];
  expect_t qTmr[$];

  wdt_shared_scaler #(.BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .wdtEnable(wdtEnable), .wdtTick(wdtTick),
    .timerSrcTick(timerSrcTick), .clearWdt(clearWdt), .sleepEntry(sleepEntry),
    .optWrEn(optWrEn), .optWrData(optWrData), .optValue(optValue),
    .wdtTimeout(wdtTimeout), .timerTick(timerTick)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs with the queue heads
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (qWdt.size() > 0 && qWdt[0].cyc == cyc) begin
        checks++;
        if (wdtTimeout !== 1'b1) begin
          fails++;
          $display("FAIL %s: wdtTimeout actual=%b expected=1 cycle %0d", qWdt[0].req, wdtTimeout, cyc);
        end
        void'(qWdt.pop_front());
      end else if (wdtTimeout) begin
        checks++; fails++;
        $display("FAIL %s: wdtTimeout actual=1 expected=0 cycle %0d",
                 (qWdt.size() > 0) ? qWdt[0].req : "R11", cyc);
      end
      if (qTmr.size() > 0 && qTmr[0].cyc == cyc) begin
        checks++;
        if (timerTick !== 1'b1) begin
          fails++;
          $display("FAIL %s: timerTick actual=%b expected=1 cycle %0d", qTmr[0].req, timerTick, cyc);
        end
        void'(qTmr.pop_front());
      end else if (timerTick) begin
        checks++; fails++;
        $display("FAIL %s: timerTick actual=1 expected=0 cycle %0d",
                 (qTmr.size() > 0) ? qTmr[0].req : "R4", cyc);
      end
    end
  end

  task automatic drive(input logic wt, input logic ts, input logic clr, input logic slp);
    wdtTick = wt; timerSrcTick = ts; clearWdt = clr; sleepEntry = slp;
    @(negedge clk);
    wdtTick = 0; timerSrcTick = 0; clearWdt = 0; sleepEntry = 0;
  endtask

  task automatic wdtTicks(input int n, input int every, input string req);
    for (int i = 1; i <= n; i++) begin
      if (every > 0 && i % every == 0) qWdt.push_back('{cyc + 1, req});
      drive(1, 0, 0, 0);
    end
  endtask

  task automatic srcTicks(input int n, input int every, input string req);
    for (int i = 1; i <= n; i++) begin
      if (every > 0 && i % every == 0) qTmr.push_back('{cyc + 1, req});
      drive(0, 1, 0, 0);
    end
  endtask

  task automatic checkOpt(input logic [7:0] exp, input string req);
    checks++;
    if (optValue !== exp) begin
      fails++;
      $display("FAIL %s: optValue actual=%h expected=%h", req, optValue, exp);
    end
  endtask

  task automatic writeOpt(input logic [7:0] data);
    optWrEn = 1'b1; optWrData = data;
    drive(0, 0, 0, 0);
    optWrEn = 1'b0;
    checkOpt(data, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkOpt(8'hFF, "R1");
    rstN = 1'b1;
    @(negedge clk);
    checkOpt(8'hFF, "R1");

    // R2 / R11: timer owns scaler, base period only
    writeOpt(8'hF0);
    drive(0, 0, 1, 0);
    wdtTicks(BASE, BASE, "R2");
    wdtTicks(BASE, BASE, "R11");
    srcTicks(4, 2, "R4");

    // R4: divide by 8 after two reassignments clear the scaler
    writeOpt(8'hF8);
    writeOpt(8'hF2);
    srcTicks(8, 8, "R4");

    // R3 / R11 / R5: watchdog owns scaler, rate 2 -> x4
    writeOpt(8'hFA);
    drive(0, 0, 1, 0);
    wdtTicks(BASE * 4, BASE * 4, "R3");
    wdtTicks(BASE * 4, BASE * 4, "R11");
    srcTicks(3, 1, "R5");

    // R6: clear restarts base and scaler
    wdtTicks(20, 0, "R6");
    drive(0, 0, 1, 0);
    wdtTicks(BASE * 4, BASE * 4, "R6");

    // R7: sleep entry restarts
    wdtTicks(10, 0, "R7");
    drive(0, 0, 0, 1);
    wdtTicks(BASE * 4, BASE * 4, "R7");

    // R8: clear coinciding with the expiring tick
    wdtTicks(BASE * 4 - 1, 0, "R8");
    drive(1, 0, 1, 0);
    wdtTicks(BASE * 4, BASE * 4, "R8");

    // R9: disabled watchdog stays quiet and restarts from zero
    wdtTicks(10, 0, "R9");
    wdtEnable = 1'b0;
    wdtTicks(50, 0, "R9");
    wdtEnable = 1'b1;
    wdtTicks(BASE * 4, BASE * 4, "R9");

    // R10: one base expiry advances scaler, reassignment clears it
    wdtTicks(10, 0, "R10");
    writeOpt(8'hF2);
    srcTicks(8, 8, "R10");

    // R12: clear leaves timer prescaler alone
    srcTicks(3, 0, "R12");
    drive(0, 0, 1, 0);
    srcTicks(5, 5, "R12");

    repeat (5) @(negedge clk);
    if (qWdt.size() != 0 || qTmr.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: pending expected pulses actual=%0d expected=0", qWdt.size() + qTmr.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule